// File: doc/BRIEF.md
# T1 Per-Channel Transmit/Receive Controller

This block applies a per-time-slot control word to a 24-channel DS1 byte stream. On the transmit side, each channel byte comes from one of three places: the system transmit stream, a shared message register, or the byte just received on the line for the same slot (remote loopback). The chosen byte can then be inverted. In the signaling frames of a D4 or ESF superframe, a robbed-bit signaling value replaces its least significant bit. On the receive side, the line byte goes to the system stream, and it is inverted when the channel's inversion bit is set. Loopback does not stop the received byte from reaching the system side.

The control words, the per-channel signaling bytes and the message register sit in a small paged register space. Writes take effect at the clock edge. Reads return data one clock later. An external counter supplies the current frame number (1 to 24 for ESF, 1 to 12 for D4) and the channel number (1 to 24), and a mode input selects ESF or D4. One byte passes per clock. Framing bits, CRC and line coding are outside this block.

Top module: `t1_chan_ctl`

## Requirements
- R1: After reset, `line_tx_byte`, `sys_rx_byte` and `reg_rdata` are 0x00, and every control word, signaling byte and the message register read back as 0x00.
- R2: Control words for channels 1..16 are at page 0, addresses 0x10..0x1F. Control words for channels 17..24 are at page 1, addresses 0x10..0x17. Signaling bytes for channels 1..16 are at page 0, addresses 0x00..0x0F. Signaling bytes for channels 17..24 are at page 1, addresses 0x00..0x07. The message register is at page 1, address 0x18. Each of these reads back what was last written to it.
- R3: A read (`reg_rd`) updates `reg_rdata` on the next clock. A read of any other page or address returns 0x00. A write there changes no stored word.
- R4: Control word bit 0 (message) selects the message register as the transmit byte. When it is clear, the transmit byte is `sys_tx_byte`. Both datapath outputs are registered and appear one clock after their inputs.
- R5: Control word bit 1 (invert) inverts the transmit byte after source selection. It also inverts the line byte that is output on `sys_rx_byte`.
- R6: Control word bit 2 (loopback) sends `line_rx_byte` back on `line_tx_byte` for the same slot. It takes priority over message mode. The received byte still goes to `sys_rx_byte`.
- R7: In ESF mode (`esf_mode`=1), the LSB of the transmit byte is replaced by signaling bit A in frame 6, B in frame 12, C in frame 18 and D in frame 24. The nibble is A=bit 3, B=bit 2, C=bit 1, D=bit 0. In all other frames, and in bits 7..1, the byte is unchanged.
- R8: In D4 mode, bit A replaces the LSB in frame 6 and bit B in frame 12. No other frame, including 18 and 24, is altered.
- R9: Control word bit 3 selects the upper signaling nibble (bits 7..4) instead of the lower one (bits 3..0). Control word bit 4 (signaling override) disables insertion for that channel.
- R10: A channel number of 0 or above 24 passes both streams through unchanged, with no inversion, loopback or signaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_page | input | 3 | Register page |
| reg_addr | input | 8 | Register address within the page |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the clock after `reg_rd` |
| esf_mode | input | 1 | 1 = ESF superframe, 0 = D4 |
| frame_num | input | 5 | Current frame in the superframe, from 1 |
| chan_num | input | 5 | Current channel, 1..24 |
| sys_tx_byte | input | 8 | System-side transmit byte |
| line_rx_byte | input | 8 | Byte received from the DS1 line |
| line_tx_byte | output | 8 | Byte to the DS1 line |
| sys_rx_byte | output | 8 | System-side receive byte |

## Verification
The bench drives inputs on the falling edge. A register write takes effect at the next rising edge, so traffic driven on the following falling edge already sees the new word. Both datapath results and read data are due at the rising edge after the inputs were driven, and the bench compares them on the falling edge after that edge, against a bench model of the register space. Assertions relate each output to the inputs of the previous cycle. This covers loopback echo, plain pass-through, out-of-range channels, D4 frames 18 and 24, and unmapped reads.

// File: rtl/t1_chan_ctl.sv
module t1_chan_ctl #(
  parameter int          NCH      = 24,
  parameter int          LO_CH    = 16,
  parameter logic [2:0]  PG_LO    = 3'd0,
  parameter logic [2:0]  PG_HI    = 3'd1,
  parameter logic [7:0]  CTL_BASE = 8'h10,
  parameter logic [7:0]  SIG_BASE = 8'h00,
  parameter logic [7:0]  MSG_ADDR = 8'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_page,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       esf_mode,
  input  logic [4:0] frame_num,
  input  logic [4:0] chan_num,
  input  logic [7:0] sys_tx_byte,
  input  logic [7:0] line_rx_byte,
  output logic [7:0] line_tx_byte,
  output logic [7:0] sys_rx_byte
);
  localparam int IW     = $clog2(NCH);
  localparam int HI_CH  = NCH - LO_CH;
  localparam int CB     = int'(CTL_BASE);
  localparam int SB     = int'(SIG_BASE);
  localparam int B_MSG  = 0;
  localparam int B_INV  = 1;
  localparam int B_LOOP = 2;
  localparam int B_HI   = 3;
  localparam int B_OVR  = 4;

  logic [7:0]    ctl_mem [NCH];
  logic [7:0]    sig_mem [NCH];
  logic [7:0]    msg_q;

  logic          hit_ctl, hit_sig, hit_msg;
  logic [IW-1:0] sel;
  int            a;

  always_comb begin
    hit_ctl = 1'b0;
    hit_sig = 1'b0;
    hit_msg = 1'b0;
    sel     = '0;
    a       = int'(reg_addr);
    if (reg_page == PG_LO) begin
      if (a >= CB && a < CB + LO_CH) begin
        hit_ctl = 1'b1;
        sel     = IW'(a - CB);
      end else if (a >= SB && a < SB + LO_CH) begin
        hit_sig = 1'b1;
        sel     = IW'(a - SB);
      end
    end else if (reg_page == PG_HI) begin
      if (a >= CB && a < CB + HI_CH) begin
        hit_ctl = 1'b1;
        sel     = IW'(LO_CH + a - CB);
      end else if (a >= SB && a < SB + HI_CH) begin
        hit_sig = 1'b1;
        sel     = IW'(LO_CH + a - SB);
      end else if (reg_addr == MSG_ADDR) begin
        hit_msg = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctl_mem[i] <= '0;
        sig_mem[i] <= '0;
      end
      msg_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        if (hit_ctl) ctl_mem[sel] <= reg_wdata;
        if (hit_sig) sig_mem[sel] <= reg_wdata;
        if (hit_msg) msg_q        <= reg_wdata;
      end
      if (reg_rd)
        reg_rdata <= hit_ctl ? ctl_mem[sel] :
                     hit_sig ? sig_mem[sel] :
                     hit_msg ? msg_q : 8'h00;
    end
  end

  logic          ch_ok;
  logic [IW-1:0] cidx;
  logic [7:0]    cur_ctl, cur_sig, src, tx_pre, tx_next;
  logic [3:0]    nib;
  logic          ins_en, ins_bit;

  assign ch_ok   = (chan_num != 5'd0) && (int'(chan_num) <= NCH);
  assign cidx    = IW'(chan_num - 5'd1);
  assign cur_ctl = ch_ok ? ctl_mem[cidx] : 8'h00;
  assign cur_sig = ch_ok ? sig_mem[cidx] : 8'h00;
  assign nib     = cur_ctl[B_HI] ? cur_sig[7:4] : cur_sig[3:0];

  assign src     = cur_ctl[B_LOOP] ? line_rx_byte :
                   cur_ctl[B_MSG]  ? msg_q : sys_tx_byte;
  assign tx_pre  = src ^ {8{cur_ctl[B_INV]}};

  always_comb begin
    ins_en  = 1'b0;
    ins_bit = 1'b0;
    case (frame_num)
      5'd6:  begin ins_en = 1'b1;     ins_bit = nib[3]; end
      5'd12: begin ins_en = 1'b1;     ins_bit = nib[2]; end
      5'd18: begin ins_en = esf_mode; ins_bit = nib[1]; end
      5'd24: begin ins_en = esf_mode; ins_bit = nib[0]; end
      default: ;
    endcase
    if (!ch_ok || cur_ctl[B_OVR]) ins_en = 1'b0;
  end

  assign tx_next = {tx_pre[7:1], ins_en ? ins_bit : tx_pre[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_tx_byte <= '0;
      sys_rx_byte  <= '0;
    end else begin
      line_tx_byte <= tx_next;
      sys_rx_byte  <= line_rx_byte ^ {8{cur_ctl[B_INV]}};
    end
  end
endmodule

// File: rtl/t1_chan_ctl_chk.sv
module t1_chan_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       esf_mode,
  input logic [4:0] frame_num,
  input logic [4:0] chan_num,
  input logic [7:0] sys_tx_byte,
  input logic [7:0] line_rx_byte,
  input logic [7:0] line_tx_byte,
  input logic [7:0] sys_rx_byte,
  input logic [7:0] cur_ctl
);
  logic in_rng, sig_fr, late_fr;
  assign in_rng  = chan_num >= 5'd1 && chan_num <= 5'd24;
  assign late_fr = frame_num == 5'd18 || frame_num == 5'd24;
  assign sig_fr  = frame_num == 5'd6 || frame_num == 5'd12 || (esf_mode && late_fr);

  AST_PASS_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rng |=> line_tx_byte == $past(sys_tx_byte) && sys_rx_byte == $past(line_rx_byte)); // R10

  AST_LOOP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng && cur_ctl[2] && (!sig_fr || cur_ctl[4]) |=> line_tx_byte == sys_rx_byte); // R6

  AST_SIG_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng && cur_ctl[2] && sig_fr |=> line_tx_byte[7:1] == sys_rx_byte[7:1]); // R7

  AST_PLAIN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng && cur_ctl[2:0] == 3'b000 && !sig_fr
    |=> line_tx_byte == $past(sys_tx_byte) && sys_rx_byte == $past(line_rx_byte)); // R4

  AST_D4_LATE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng && !esf_mode && late_fr && cur_ctl[2:0] == 3'b000
    |=> line_tx_byte == $past(sys_tx_byte)); // R8

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr >= 8'h20 |=> reg_rdata == 8'h00); // R3
endmodule

bind t1_chan_ctl t1_chan_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .esf_mode(esf_mode), .frame_num(frame_num), .chan_num(chan_num),
  .sys_tx_byte(sys_tx_byte), .line_rx_byte(line_rx_byte),
  .line_tx_byte(line_tx_byte), .sys_rx_byte(sys_rx_byte), .cur_ctl(cur_ctl)
);

// File: tb/t1_chan_ctl_tb.sv
module t1_chan_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_page = '0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic       esf_mode = 1'b0;
  logic [4:0] frame_num = 5'd1, chan_num = 5'd0;
  logic [7:0] sys_tx_byte = '0, line_rx_byte = '0, line_tx_byte, sys_rx_byte;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_ctl [24];
  logic [7:0] m_sig [24];
  logic [7:0] m_msg;

  always #5 clk = ~clk;

  t1_chan_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_page(reg_page),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .esf_mode(esf_mode), .frame_num(frame_num), .chan_num(chan_num),
    .sys_tx_byte(sys_tx_byte), .line_rx_byte(line_rx_byte),
    .line_tx_byte(line_tx_byte), .sys_rx_byte(sys_rx_byte)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic void model_write(logic [2:0] p, logic [7:0] a, logic [7:0] d);
    int ai = int'(a);
    if (p == 3'd0 && ai >= 16 && ai <= 31) m_ctl[ai - 16] = d;
    else if (p == 3'd0 && ai <= 15)         m_sig[ai] = d;
    else if (p == 3'd1 && ai >= 16 && ai <= 23) m_ctl[ai] = d;
    else if (p == 3'd1 && ai <= 7)          m_sig[ai + 16] = d;
    else if (p == 3'd1 && ai == 24)         m_msg = d;
  endfunction

  function automatic logic [7:0] model_read(logic [2:0] p, logic [7:0] a);
    int ai = int'(a);
    if (p == 3'd0 && ai >= 16 && ai <= 31) return m_ctl[ai - 16];
    if (p == 3'd0 && ai <= 15)             return m_sig[ai];
    if (p == 3'd1 && ai >= 16 && ai <= 23) return m_ctl[ai];
    if (p == 3'd1 && ai <= 7)              return m_sig[ai + 16];
    if (p == 3'd1 && ai == 24)             return m_msg;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_tx(int ch, int fr, bit esf, logic [7:0] sys, logic [7:0] rx);
    logic [7:0] c, s, b;
    logic [3:0] n;
    if (ch < 1 || ch > 24) return sys;
    c = m_ctl[ch - 1];
    s = m_sig[ch - 1];
    if (c[2]) b = rx; else if (c[0]) b = m_msg; else b = sys;
    if (c[1]) b = ~b;
    n = c[3] ? s[7:4] : s[3:0];
    if (!c[4]) begin
      if (fr == 6)              b[0] = n[3];
      else if (fr == 12)        b[0] = n[2];
      else if (esf && fr == 18) b[0] = n[1];
      else if (esf && fr == 24) b[0] = n[0];
    end
    return b;
  endfunction

  function automatic logic [7:0] exp_rx(int ch, logic [7:0] rx);
    if (ch < 1 || ch > 24) return rx;
    return m_ctl[ch - 1][1] ? ~rx : rx;
  endfunction

  task automatic wr(logic [2:0] p, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b0; reg_page = p; reg_addr = a; reg_wdata = d;
    chan_num = 5'd0;
    model_write(p, a, d);
  endtask

  task automatic rd(string tag, logic [2:0] p, logic [7:0] a);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_page = p; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, model_read(p, a));
  endtask

  task automatic traffic(string tag, int ch, int fr, bit esf, logic [7:0] sys, logic [7:0] rx);
    logic [7:0] et, er;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chan_num = 5'(ch); frame_num = 5'(fr); esf_mode = esf;
    sys_tx_byte = sys; line_rx_byte = rx;
    et = exp_tx(ch, fr, esf, sys, rx);
    er = exp_rx(ch, rx);
    @(negedge clk);
    chk({tag, " tx"}, line_tx_byte, et);
    chk({tag, " rx"}, sys_rx_byte, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) begin m_ctl[i] = 8'h00; m_sig[i] = 8'h00; end
    m_msg = 8'h00;
    void'($urandom(32'd4077));
    repeat (3) @(negedge clk);
    chk("R1 tx reset", line_tx_byte, 8'h00);
    chk("R1 rx reset", sys_rx_byte, 8'h00);
    rst_n = 1'b1;
    rd("R1 ctl ch1 reset", 3'd0, 8'h10);
    rd("R1 msg reset", 3'd1, 8'h18);

    // R2 map corners
    wr(3'd0, 8'h10, 8'h11); wr(3'd0, 8'h1F, 8'h06); wr(3'd1, 8'h10, 8'h0C); wr(3'd1, 8'h17, 8'h02);
    wr(3'd0, 8'h00, 8'h3C); wr(3'd1, 8'h07, 8'hC3); wr(3'd1, 8'h18, 8'h5A);
    rd("R2 ctl ch1", 3'd0, 8'h10);   rd("R2 ctl ch16", 3'd0, 8'h1F);
    rd("R2 ctl ch17", 3'd1, 8'h10);  rd("R2 ctl ch24", 3'd1, 8'h17);
    rd("R2 sig ch1", 3'd0, 8'h00);   rd("R2 sig ch24", 3'd1, 8'h07);
    rd("R2 msg", 3'd1, 8'h18);

    // R3 unmapped writes ignored, unmapped reads zero
    wr(3'd1, 8'h19, 8'hFF); wr(3'd1, 8'h08, 8'hFF); wr(3'd2, 8'h10, 8'hFF); wr(3'd0, 8'h20, 8'hFF);
    rd("R3 unmapped read", 3'd1, 8'h19);
    rd("R3 unmapped read p2", 3'd2, 8'h10);
    rd("R3 ch24 untouched", 3'd1, 8'h17);
    rd("R3 msg untouched", 3'd1, 8'h18);
    for (int c = 17; c <= 24; c++) rd("R3 hi page sweep", 3'd1, 8'(c - 1));

    // R4 message source
    wr(3'd0, 8'h14, 8'h01);
    traffic("R4 msg ch5", 5, 3, 1'b1, 8'h77, 8'h22);
    wr(3'd0, 8'h14, 8'h00);
    traffic("R4 sys ch5", 5, 3, 1'b1, 8'h77, 8'h22);
    // R5 inversion both ways
    wr(3'd0, 8'h14, 8'h02);
    traffic("R5 invert ch5", 5, 2, 1'b0, 8'h0F, 8'h33);
    // R6 loopback beats message
    wr(3'd0, 8'h14, 8'h05);
    traffic("R6 loop ch5", 5, 4, 1'b1, 8'h77, 8'hA6);
    // R7 ESF frames, lower nibble 0101: A=0 B=1 C=0 D=1
    wr(3'd0, 8'h12, 8'h00); wr(3'd0, 8'h02, 8'hA5);
    traffic("R7 esf f6", 3, 6, 1'b1, 8'hFF, 8'h00);
    traffic("R7 esf f12", 3, 12, 1'b1, 8'h00, 8'h00);
    traffic("R7 esf f18", 3, 18, 1'b1, 8'hFF, 8'h00);
    traffic("R7 esf f24", 3, 24, 1'b1, 8'h00, 8'h00);
    traffic("R7 esf f7", 3, 7, 1'b1, 8'hFE, 8'h00);
    // R8 D4 frames
    traffic("R8 d4 f6", 3, 6, 1'b0, 8'hFF, 8'h00);
    traffic("R8 d4 f12", 3, 12, 1'b0, 8'h00, 8'h00);
    traffic("R8 d4 f18", 3, 18, 1'b0, 8'hFF, 8'h00);
    traffic("R8 d4 f24", 3, 24, 1'b0, 8'h00, 8'h00);
    // R9 upper nibble 1010, then override
    wr(3'd0, 8'h12, 8'h08);
    traffic("R9 upper f6", 3, 6, 1'b1, 8'h00, 8'h00);
    traffic("R9 upper f24", 3, 24, 1'b1, 8'hFF, 8'h00);
    wr(3'd0, 8'h12, 8'h18);
    traffic("R9 override f6", 3, 6, 1'b1, 8'h00, 8'h00);
    // R10 out-of-range channels
    wr(3'd1, 8'h17, 8'h07);
    traffic("R10 ch0", 0, 6, 1'b1, 8'h5C, 8'hC5);
    traffic("R10 ch25", 25, 12, 1'b0, 8'h5C, 8'hC5);
    traffic("R6 loop ch24", 24, 6, 1'b1, 8'h5C, 8'hC5);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < 600; k++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 3) begin
        wr(3'($urandom_range(0, 2)), 8'($urandom_range(0, 33)), 8'($urandom));
      end else if (r < 4) begin
        rd("R2 random read", 3'($urandom_range(0, 2)), 8'($urandom_range(0, 33)));
      end else begin
        bit e = 1'($urandom);
        int f = e ? int'($urandom_range(1, 24)) : int'($urandom_range(1, 12));
        traffic("R7 random traffic", int'($urandom_range(0, 25)), f, e, 8'($urandom), 8'($urandom));
      end
    end

    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule